// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Slave

This block is the device side of a serial real-time-clock register space. It is meant to sit on the far end of an SPI link so that a clock-chip master can be exercised against a register map that behaves like a real part. The block samples chip enable, serial clock and serial data in with the system clock. It takes the first byte of every chip-enable window as a command, then reads or writes a run of consecutive registers until chip enable drops. No timekeeping, alarm matching or interrupt pins are modelled. The registers only hold what the master puts in them.

A transfer moves through four named states. `ST_IDLE` holds while chip enable is low, and it moves to `ST_ADDR` once chip enable is seen high. `ST_ADDR` collects the command byte. When the eighth bit arrives it goes to `ST_WR` if the top bit is set and to `ST_RD` if it is clear. `ST_WR` and `ST_RD` stay in place byte after byte. From any state, a low chip enable returns the machine to `ST_IDLE`. Writes to everything except the control register are gated by a protect bit, and that bit is set after reset.

Top module: `rtc_spi_slave`

## Requirements
- R1: The first byte after chip enable goes high is a command. Bit 7 = 1 selects write and bit 7 = 0 selects read, and bits 6:0 give the starting address. A two-byte read returns the register contents in the second byte.
- R2: Each further byte in the same chip-enable window uses the next address, so that one command byte can be followed by a burst of bytes. A burst that runs from 0x1F goes on to 0x20.
- R3: Addresses 0x00–0x06 (time and date), 0x07–0x0E (two alarm sets of four bytes) and 0x10–0x11 (status and charger setting) are plain 8-bit storage that reads back what was last written.
- R4: Control sits at address 0x0F and stores only bit 6 (protect), bit 2 (1 Hz output enable), bit 1 and bit 0 (alarm interrupt enables). Bits 7 and 5:3 read 0.
- R5: While control bit 6 is 1, a write to any address other than 0x0F leaves that location unchanged.
- R6: A control write that is made while bit 6 is 1 changes only bit 6. Bits 2:0 keep their value, so clearing the whole register from the protected state takes two writes of 0x00. The protect value that applies to a byte is the one held before that byte completes.
- R7: Addresses 0x12–0x1F read as 0x00 and ignore writes.
- R8: User RAM occupies 0x20 up to 0x20+UR_DEPTH−1 (0x7F by default). In a burst, the address after the last RAM byte is 0x20.
- R9: When chip enable goes low, the transfer ends and any partly shifted bits are discarded. The next window again starts with a command byte.
- R10: MOSI is taken on the falling SCK edge and MISO changes after the rising edge, most significant bit first. MISO is 0 during the command byte and whenever no read is in progress.
- R11: After reset, control reads 0x40, every other location reads 0x00 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_ce | input | 1 | Chip enable, active high |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |

## Verification
Two events land on the same system-clock edge: the completion of a byte addressed to control, and the protect test for that same byte. The protect value held before the byte must decide the outcome. The bench sets up this case with a burst that starts at 0x0F while the register is protected. The burst writes 0x07 to control and then writes to status and the charger setting. The bench then reads back control as 0x00, because only the protect bit moved, and reads back the two following bytes as stored. The other shared edge is the store of a completed byte, the pointer step and the wrap from the last RAM byte. These are judged by reading back both sides of a burst that crosses 0x7F.

// File: rtl/rtc_spi_pkg.sv
`timescale 1ns/1ps
package rtc_spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } xfer_state_t;

    localparam int          ADDR_W        = 7;
    localparam int          RAM_BASE_INT  = 32;
    localparam int          NUM_PLAIN     = 18;
    localparam logic [6:0]  A_CTRL        = 7'h0F;
    localparam logic [6:0]  A_RAM_BASE    = 7'h20;
    localparam int          CTRL_WP_BIT   = 6;
    localparam logic [7:0]  CTRL_KEEP     = 8'h47;
    localparam logic [7:0]  CTRL_RESET    = 8'h40;

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [STAGES-1:0][WIDTH-1:0] sy_q;
    logic [WIDTH-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q   <= '0;
            prev_q <= '0;
        end else begin
            sy_q   <= {sy_q[STAGES-2:0], pin_i};
            prev_q <= sy_q[STAGES-1];
        end
    end

    assign lvl_o  = sy_q[STAGES-1];
    assign rise_o = sy_q[STAGES-1] & ~prev_q;
    assign fall_o = ~sy_q[STAGES-1] & prev_q;

endmodule

// File: rtl/rtc_reg_store.sv
`timescale 1ns/1ps
module rtc_reg_store
    import rtc_spi_pkg::*;
#(
    parameter int UR_DEPTH = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int RW = $clog2(UR_DEPTH);

    logic [NUM_PLAIN-1:0][7:0] plain_q;
    logic [UR_DEPTH-1:0][7:0]  ram_q;
    logic [7:0]                ctrl_q;
    logic                      wp;
    logic [ADDR_W-1:0]         wr_off, rd_off;
    logic                      wr_plain, wr_ram, rd_plain, rd_ram;

    assign wp       = ctrl_q[CTRL_WP_BIT];
    assign wr_off   = wr_addr - A_RAM_BASE;
    assign rd_off   = rd_addr - A_RAM_BASE;
    assign wr_plain = (wr_addr < 7'd18) && (wr_addr != A_CTRL);
    assign rd_plain = (rd_addr < 7'd18) && (rd_addr != A_CTRL);
    assign wr_ram   = (wr_addr >= A_RAM_BASE) && ({1'b0, wr_off} < 8'(UR_DEPTH));
    assign rd_ram   = (rd_addr >= A_RAM_BASE) && ({1'b0, rd_off} < 8'(UR_DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plain_q <= '0;
            ram_q   <= '0;
            ctrl_q  <= CTRL_RESET;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                if (wp) ctrl_q[CTRL_WP_BIT] <= wr_data[CTRL_WP_BIT];
                else    ctrl_q <= wr_data & CTRL_KEEP;
            end else if (!wp) begin
                if (wr_plain)    plain_q[wr_addr[4:0]] <= wr_data;
                else if (wr_ram) ram_q[wr_off[RW-1:0]] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == A_CTRL) rd_data = ctrl_q;
        else if (rd_plain)     rd_data = plain_q[rd_addr[4:0]];
        else if (rd_ram)       rd_data = ram_q[rd_off[RW-1:0]];
    end

    // R5
    wp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp && wr_addr != A_CTRL) |=> ($stable(plain_q) && $stable(ram_q)));

    // R6
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp && wr_addr == A_CTRL) |=> (ctrl_q[2:0] == $past(ctrl_q[2:0])));

    // R7
    gap_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 7'h12 && wr_addr < A_RAM_BASE)
        |=> ($stable(plain_q) && $stable(ram_q) && $stable(ctrl_q)));

endmodule

// File: rtl/rtc_spi_slave.sv
`timescale 1ns/1ps
module rtc_spi_slave
    import rtc_spi_pkg::*;
#(
    parameter int UR_DEPTH    = 96,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_ce,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam logic [ADDR_W-1:0] RAM_LAST = 7'(RAM_BASE_INT + UR_DEPTH - 1);

    logic [2:0]        pin_lvl, pin_rise, pin_fall;
    logic              ce_s, sck_rise, sck_fall, mosi_s, unused_edges;
    xfer_state_t       state_q, state_d;
    logic [2:0]        bit_cnt_q;
    logic [6:0]        rx_q;
    logic [7:0]        rx_byte, tx_q, rd_data;
    logic [ADDR_W-1:0] ptr_q, ptr_next, ld_addr;
    logic              byte_done, wr_en, miso_q;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({spi_ce, spi_sck, spi_mosi}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign ce_s         = pin_lvl[2];
    assign mosi_s       = pin_lvl[0];
    assign sck_rise     = pin_rise[1];
    assign sck_fall     = pin_fall[1];
    assign unused_edges = ^{pin_rise[2], pin_rise[0], pin_fall[2], pin_fall[0]};

    assign rx_byte   = {rx_q, mosi_s};
    assign byte_done = ce_s && sck_fall && (bit_cnt_q == 3'd7) && (state_q != ST_IDLE);
    assign ptr_next  = (ptr_q == RAM_LAST) ? A_RAM_BASE : ptr_q + 7'd1;
    assign ld_addr   = (state_q == ST_ADDR) ? rx_byte[6:0] : ptr_next;
    assign wr_en     = byte_done && (state_q == ST_WR);

    rtc_reg_store #(.UR_DEPTH(UR_DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr_q),
        .wr_data (rx_byte),
        .rd_addr (ld_addr),
        .rd_data (rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!ce_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ADDR;
                ST_ADDR: if (byte_done) state_d = rx_byte[7] ? ST_WR : ST_RD;
                ST_WR:   state_d = ST_WR;
                ST_RD:   state_d = ST_RD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            ptr_q     <= '0;
            tx_q      <= '0;
            miso_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || !ce_s) begin
                bit_cnt_q <= '0;
            end else if (sck_fall) begin
                bit_cnt_q <= bit_cnt_q + 3'd1;
                rx_q      <= rx_byte[6:0];
            end
            if (byte_done) begin
                ptr_q <= ld_addr;
                tx_q  <= rd_data;
            end
            if (state_q != ST_RD) begin
                miso_q <= 1'b0;
            end else if (sck_rise) begin
                miso_q <= tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
            end
        end
    end

    assign spi_miso = miso_q;

    // R1
    cmd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && byte_done) |=> ((state_q == ST_WR) == $past(rx_byte[7])));

    // R9
    ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_s) |=> (state_q == ST_IDLE));

    // R10
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_RD) |-> !spi_miso);

    // R8
    ram_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state_q != ST_ADDR && ptr_q == RAM_LAST) |=> (ptr_q == A_RAM_BASE));

endmodule

// File: tb/test_rtc_spi_slave.sv
`timescale 1ns/1ps
module test_rtc_spi_slave;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso;
    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_spi_slave i_rtc_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_ce(ce), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            sck = 1'b1; mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b0;
            wait_clk(HALF);
        end
    endtask

    task automatic ce_on();
        ce = 1'b1; wait_clk(HALF);
    endtask

    task automatic ce_off();
        wait_clk(HALF); ce = 1'b0; mosi = 1'b0; wait_clk(HALF);
    endtask

    task automatic burst_wr(input logic [6:0] a, input logic [7:0] d [8], input int n);
        logic [7:0] r;
        ce_on();
        xfer_bits({1'b1, a}, 8, r);
        for (int k = 0; k < n; k++) xfer_bits(d[k], 8, r);
        ce_off();
    endtask

    task automatic burst_rd(input logic [6:0] a, input int n, output logic [7:0] q [8],
                            output logic [7:0] first);
        ce_on();
        xfer_bits({1'b0, a}, 8, first);
        for (int k = 0; k < 8; k++) q[k] = '0;
        for (int k = 0; k < n; k++) xfer_bits(8'h00, 8, q[k]);
        ce_off();
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] buf8 [8];
        buf8[0] = d;
        for (int k = 1; k < 8; k++) buf8[k] = '0;
        burst_wr(a, buf8, 1);
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] q [8];
        logic [7:0] f;
        burst_rd(a, 1, q, f);
        check(req, $sformatf("read %02h", a), q[0], exp);
    endtask

    task automatic t_reset();
        logic [7:0] q [8];
        logic [7:0] f;
        check("R11", "miso after reset", {7'd0, miso}, 8'h00);
        burst_rd(A(8'h0F), 1, q, f);
        check("R11", "control after reset", q[0], 8'h40);
        check("R10", "miso during command byte", f, 8'h00);
        rd_chk("R11", 7'h00, 8'h00);
        rd_chk("R11", 7'h20, 8'h00);
    endtask

    function automatic logic [6:0] A(input logic [7:0] v);
        return v[6:0];
    endfunction

    task automatic t_protect();
        wr1(7'h01, 8'h59);
        rd_chk("R5", 7'h01, 8'h00);
        wr1(7'h25, 8'hAA);
        rd_chk("R5", 7'h25, 8'h00);
    endtask

    task automatic t_ctrl();
        wr1(7'h0F, 8'h00);
        rd_chk("R6", 7'h0F, 8'h00);
        wr1(7'h0F, 8'hFF);
        rd_chk("R4", 7'h0F, 8'h47);
        wr1(7'h0F, 8'h00);
        rd_chk("R6", 7'h0F, 8'h07);
        wr1(7'h0F, 8'h00);
        rd_chk("R6", 7'h0F, 8'h00);
    endtask

    task automatic t_time_burst();
        logic [7:0] d [8] = '{8'h45, 8'h30, 8'h12, 8'h03, 8'h28, 8'h11, 8'h14, 8'h00};
        logic [7:0] q [8];
        logic [7:0] f;
        burst_wr(7'h00, d, 7);
        burst_rd(7'h00, 7, q, f);
        for (int k = 0; k < 7; k++) check("R2", $sformatf("burst time %0d", k), q[k], d[k]);
        rd_chk("R1", 7'h04, 8'h28);
    endtask

    task automatic t_alarms();
        logic [7:0] d [8];
        for (int k = 0; k < 8; k++) d[k] = 8'(k * 17 + 1);
        burst_wr(7'h07, d, 8);
        for (int k = 0; k < 8; k++) rd_chk("R3", 7'(7 + k), d[k]);
    endtask

    task automatic t_ctrl_burst();
        logic [7:0] d [8] = '{8'h07, 8'h33, 8'h5C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr1(7'h0F, 8'h40);
        burst_wr(7'h0F, d, 3);
        rd_chk("R6", 7'h0F, 8'h00);
        rd_chk("R3", 7'h10, 8'h33);
        rd_chk("R3", 7'h11, 8'h5C);
    endtask

    task automatic t_gap();
        logic [7:0] d [8] = '{8'hA5, 8'h77, 8'h66, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr1(7'h12, 8'hFF);
        wr1(7'h1F, 8'hFF);
        rd_chk("R7", 7'h12, 8'h00);
        rd_chk("R7", 7'h1F, 8'h00);
        burst_wr(7'h11, d, 3);
        rd_chk("R3", 7'h11, 8'hA5);
        rd_chk("R7", 7'h13, 8'h00);
        d[0] = 8'hEE; d[1] = 8'h21;
        burst_wr(7'h1F, d, 2);
        rd_chk("R2", 7'h20, 8'h21);
    endtask

    task automatic t_wrap();
        logic [7:0] d [8] = '{8'h9A, 8'h6B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        logic [7:0] q [8];
        logic [7:0] f;
        burst_wr(7'h7F, d, 2);
        rd_chk("R8", 7'h7F, 8'h9A);
        rd_chk("R8", 7'h20, 8'h6B);
        burst_rd(7'h7F, 2, q, f);
        check("R8", "wrap read first", q[0], 8'h9A);
        check("R8", "wrap read second", q[1], 8'h6B);
    endtask

    task automatic t_restart();
        logic [7:0] r;
        wr1(7'h24, 8'h5A);
        wr1(7'h25, 8'h3C);
        rd_chk("R9", 7'h24, 8'h5A);
        rd_chk("R9", 7'h25, 8'h3C);
        ce_on();
        xfer_bits(8'hA6, 8, r);
        xfer_bits(8'hFF, 4, r);
        ce_off();
        rd_chk("R9", 7'h26, 8'h00);
        wr1(7'h26, 8'h81);
        rd_chk("R9", 7'h26, 8'h81);
    endtask

    task automatic t_protect_again();
        wr1(7'h0F, 8'h40);
        wr1(7'h00, 8'h01);
        rd_chk("R5", 7'h00, 8'h45);
        wr1(7'h7F, 8'h11);
        rd_chk("R5", 7'h7F, 8'h9A);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_protect();
        t_ctrl();
        t_time_burst();
        t_alarms();
        t_ctrl_burst();
        t_gap();
        t_wrap();
        t_restart();
        t_protect_again();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule